// File: doc/BRIEF.md
# Transmit/Receive Switch Timing Delay

This block drives a single antenna switch state bit that follows the transmitter's activity flag, but only after a programmable number of clock cycles. Entering transmit and returning to receive each have their own delay. Software can therefore line the switch edge up with the latency of the transmit pipeline, which can differ between the start and the end of a burst.

Two delay values are loaded through a small write-only register port. A change in the activity flag starts a countdown, using the delay that belongs to the direction of the change. When the countdown expires, the switch bit takes the new direction. If the flag changes again before expiry, the pending change is dropped and a new countdown starts for the new direction. A delay of zero passes the change straight through in the cycle it is seen.

Top module: `atr_switch_delay`

## Requirements
- R1: A write with `wrAddr` = 2 stores `wrData[11:0]` as the transmit-going delay; bits 31:12 are ignored.
- R2: A write with `wrAddr` = 3 stores `wrData[11:0]` as the receive-going delay.
- R3: Writes to any address other than 2 or 3 change neither delay.
- R4: Suppose `txActive` first reads 1 in cycle c and the transmit delay D is at least 1. Then `atrTx` stays 0 through cycle c+D-1 and reads 1 from cycle c+D.
- R5: Suppose `txActive` first reads 0 in cycle c and the receive delay D is at least 1. Then `atrTx` stays 1 through cycle c+D-1 and reads 0 from cycle c+D.
- R6: When the delay for the new direction is 0, `atrTx` takes the new direction in the same cycle c.
- R7: A new edge of `txActive` before a countdown expires cancels the pending change. `atrTx` holds its value until the countdown for the new direction expires.
- R8: A delay write that lands during a countdown leaves that countdown unchanged. The new value applies from the next edge of `txActive`.
- R9: Synchronous reset clears both delays and the countdown and sets `atrTx` to 0. The remembered `txActive` level is also cleared, so a high flag right after reset counts as a rising edge.
- R10: With no edge and no countdown pending, the registered switch state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txActive | input | 1 | Transmitter activity flag |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 7 | Register write address |
| wrData | input | 32 | Register write data |
| atrTx | output | 1 | Switch state, 1 = transmit |

## Verification
The bench uses the default parameters: 12-bit delays, a 7-bit address and a 32-bit data word. Register addresses are 2 and 3. Delays of 3 and 2 cycles are short enough to check every cycle of a countdown. They also make it possible to cancel a countdown one cycle before it would have expired. Writing all ones into the upper data bits shows that only the low 12 bits take effect. Delays of 0 exercise the same-cycle bypass. Reset is applied in the transmit state to show that both the state and the delays are cleared.

// File: rtl/atr_pkg.sv
package atr_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // reload counter for direction dirTx
    logic dirTx;   // 1: transmit-going delay, 0: receive-going delay
    logic dec;     // count down one step
  } atrStrobe_t;
endpackage

// File: rtl/atr_dp.sv
module atr_dp
  import atr_pkg::*;
#(
  parameter int DLY_W   = 12,
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 32,
  parameter int TX_ADDR = 2,
  parameter int RX_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  atrStrobe_t        str,
  output logic              selZero,
  output logic              cntOne
);
  localparam logic [ADDR_W-1:0] TXA = ADDR_W'(TX_ADDR);
  localparam logic [ADDR_W-1:0] RXA = ADDR_W'(RX_ADDR);
  localparam logic [DLY_W-1:0]  ONE = DLY_W'(1);

  logic [DLY_W-1:0] txDly, rxDly, cnt, selDly;
  logic             unusedHiBits;

  assign unusedHiBits = ^wrData[DATA_W-1:DLY_W];
  assign selDly  = str.dirTx ? txDly : rxDly;
  assign selZero = (selDly == '0);
  assign cntOne  = (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      txDly <= '0;
      rxDly <= '0;
    end else if (wrEn) begin
      if (wrAddr == TXA) txDly <= wrData[DLY_W-1:0];
      if (wrAddr == RXA) rxDly <= wrData[DLY_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                       cnt <= '0;
    else if (str.load)             cnt <= selDly;
    else if (str.dec && cnt != '0) cnt <= cnt - ONE;
  end

  // R3
  tx_dly_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && wrAddr == TXA) |=> $stable(txDly));
  // R3
  rx_dly_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && wrAddr == RXA) |=> $stable(rxDly));
  // R8
  cnt_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !str.load |=> cnt <= $past(cnt));
endmodule

// File: rtl/atr_ctrl.sv
module atr_ctrl
  import atr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       txActive,
  input  logic       selZero,
  input  logic       cntOne,
  output atrStrobe_t str,
  output logic       atrTx
);
  logic txPrev, pending, target, atrState;
  logic edgeSeen, zeroNow, expireNow;

  assign edgeSeen  = txActive ^ txPrev;
  assign zeroNow   = edgeSeen && selZero;
  assign expireNow = !edgeSeen && pending && cntOne;

  assign str.load  = edgeSeen;
  assign str.dirTx = txActive;
  assign str.dec   = pending && !edgeSeen;

  assign atrTx = zeroNow ? txActive : (expireNow ? target : atrState);

  always_ff @(posedge clk) begin
    if (rst) begin
      txPrev   <= 1'b0;
      pending  <= 1'b0;
      target   <= 1'b0;
      atrState <= 1'b0;
    end else begin
      txPrev <= txActive;
      if (edgeSeen) begin
        target <= txActive;
        if (selZero) begin
          atrState <= txActive;
          pending  <= 1'b0;
        end else begin
          pending  <= 1'b1;
        end
      end else if (expireNow) begin
        atrState <= target;
        pending  <= 1'b0;
      end
    end
  end

  // R9
  reset_rx_chk: assert property (@(posedge clk) $past(rst) |-> !atrState && !pending);
  // R10
  state_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!edgeSeen && !pending) |=> atrState == $past(atrState));
  // R4
  arm_chk: assert property (@(posedge clk) disable iff (rst)
    (edgeSeen && !selZero) |=> pending && (target == $past(txActive)));
  // R7
  edge_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (edgeSeen && !selZero) |=> atrState == $past(atrState));
endmodule

// File: rtl/atr_switch_delay.sv
module atr_switch_delay
  import atr_pkg::*;
#(
  parameter int DLY_W   = 12,
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 32,
  parameter int TX_ADDR = 2,
  parameter int RX_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txActive,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              atrTx
);
  atrStrobe_t str;
  logic       selZero, cntOne;

  atr_ctrl uCtrl (
    .clk(clk), .rst(rst), .txActive(txActive),
    .selZero(selZero), .cntOne(cntOne), .str(str), .atrTx(atrTx)
  );

  atr_dp #(
    .DLY_W(DLY_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .TX_ADDR(TX_ADDR), .RX_ADDR(RX_ADDR)
  ) uDp (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .str(str), .selZero(selZero), .cntOne(cntOne)
  );
endmodule

// File: tb/tb_atr_switch_delay.sv
module tb_atr_switch_delay;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        txActive = 1'b0;
  logic        wrEn = 1'b0;
  logic [6:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        atrTx;
  int          checks = 0;
  int          failures = 0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atr_switch_delay dut (
    .clk(clk), .rst(rst), .txActive(txActive), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .atrTx(atrTx)
  );

  // {wrEn, wrAddr, wrData, txActive, expected atrTx}
  localparam logic [41:0] VEC [NVEC] = '{
    {1'b1, 7'd2, 32'hFFFF_F003, 1'b0, 1'b0},  // R1 tx delay 3, upper bits ignored
    {1'b1, 7'd3, 32'h0000_0002, 1'b0, 1'b0},  // R2 rx delay 2
    {1'b1, 7'd5, 32'h0000_0007, 1'b0, 1'b0},  // R3 ignored address
    {1'b0, 7'd0, 32'h0,         1'b1, 1'b0},  // R4 rising edge, cycle c
    {1'b0, 7'd0, 32'h0,         1'b1, 1'b0},
    {1'b0, 7'd0, 32'h0,         1'b1, 1'b0},
    {1'b0, 7'd0, 32'h0,         1'b1, 1'b1},  // c+3
    {1'b0, 7'd0, 32'h0,         1'b1, 1'b1},
    {1'b0, 7'd0, 32'h0,         1'b0, 1'b1},  // R5 falling edge
    {1'b0, 7'd0, 32'h0,         1'b0, 1'b1},
    {1'b0, 7'd0, 32'h0,         1'b0, 1'b0},  // c+2
    {1'b0, 7'd0, 32'h0,         1'b0, 1'b0},
    {1'b0, 7'd0, 32'h0,         1'b1, 1'b0},  // R7 rising edge
    {1'b0, 7'd0, 32'h0,         1'b1, 1'b0},
    {1'b0, 7'd0, 32'h0,         1'b0, 1'b0},  // R7 cancel by falling edge
    {1'b0, 7'd0, 32'h0,         1'b0, 1'b0},  // old expiry would be here
    {1'b0, 7'd0, 32'h0,         1'b0, 1'b0},
    {1'b0, 7'd0, 32'h0,         1'b0, 1'b0}
  };

  task automatic check(input logic exp, input string tag);
    checks++;
    if (atrTx !== exp) begin
      failures++;
      $display("FAIL %s: atrTx=%b expected=%b", tag, atrTx, exp);
    end
  endtask

  task automatic step(input logic w, input logic [6:0] a, input logic [31:0] d,
                      input logic tx, input logic exp, input string tag);
    @(negedge clk);
    wrEn = w; wrAddr = a; wrData = d; txActive = tx;
    #2;
    check(exp, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: done=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    check(1'b0, "R9 reset state");

    for (int i = 0; i < NVEC; i++)
      step(VEC[i][41], VEC[i][40:34], VEC[i][33:2], VEC[i][1], VEC[i][0],
           $sformatf("table row %0d (R1 R2 R3 R4 R5 R7)", i));

    // R8: write during transmit countdown does not alter it
    step(1'b0, 7'd0, 32'd0, 1'b1, 1'b0, "R8 edge");
    step(1'b1, 7'd2, 32'd1, 1'b1, 1'b0, "R8 write mid-count");
    step(1'b0, 7'd0, 32'd0, 1'b1, 1'b0, "R8 c+2");
    step(1'b0, 7'd0, 32'd0, 1'b1, 1'b1, "R8 c+3 old delay used");
    step(1'b0, 7'd0, 32'd0, 1'b0, 1'b1, "R5 fall c");
    step(1'b0, 7'd0, 32'd0, 1'b0, 1'b1, "R5 fall c+1");
    step(1'b0, 7'd0, 32'd0, 1'b0, 1'b0, "R5 fall c+2");
    step(1'b0, 7'd0, 32'd0, 1'b1, 1'b0, "R8 next edge c");
    step(1'b0, 7'd0, 32'd0, 1'b1, 1'b1, "R8 new delay 1 at c+1");

    // R6: zero delays pass straight through
    step(1'b1, 7'd2, 32'd0, 1'b1, 1'b1, "R6 set tx delay 0");
    step(1'b1, 7'd3, 32'd0, 1'b1, 1'b1, "R6 set rx delay 0");
    step(1'b0, 7'd0, 32'd0, 1'b0, 1'b0, "R6 falling same cycle");
    step(1'b0, 7'd0, 32'd0, 1'b1, 1'b1, "R6 rising same cycle");
    step(1'b1, 7'd2, 32'd4, 1'b1, 1'b1, "R10 hold while writing");

    // R9: reset in transmit state
    @(negedge clk);
    wrEn = 1'b0; rst = 1'b1; txActive = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    #2;
    check(1'b0, "R9 state cleared");
    step(1'b0, 7'd0, 32'd0, 1'b1, 1'b1, "R9 delays cleared");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule